// File: doc/BRIEF.md
# Fractional Controller Clock Divider

This block derives the clock-enable for a converter controller from one of two source clocks. Both sources are modelled inside a single fast clock domain as enable strobes: one strobe marks the cycles of an alternate (PLL-derived) source and the other marks bus-clock cycles. A two-bit select code chooses which strobe is counted, and a gate input switches the whole divider on or off. The result is a train of one-cycle enable pulses whose average spacing, counted in source ticks, is the integer part plus one plus a programmable fraction.

The fraction is produced by an accumulator. At each output boundary the numerator is added to a running remainder. When the sum reaches the denominator, the denominator is taken off and the next output period is lengthened by one source tick. The integer part and the fraction are both sampled only at output boundaries, so a change applied mid-period never truncates or splits a period. Whenever the divider is off, the counter and the remainder restart. The first period after switching on is therefore always the plain integer length.

Top module: `fracdiv_clkgen`

## Requirements
- R1: While reset is held, `ctl_clk_en` is 0. Out of reset the stored integer divisor is 15 and the remainder is 0. If the divider is already running when reset is released, the first pulse comes after 16 source ticks, whatever `int_div` holds.
- R2: Select code 1 counts `src_alt_stb` and ignores `src_bus_stb`. Code 2 counts `src_bus_stb` and ignores `src_alt_stb`. Codes 0 and 3 count nothing and produce no pulses.
- R3: While `gate_en` is 0, no pulse is produced, and the tick count and fractional remainder return to 0.
- R4: With `frac_num` = 0 and a constant `int_div` = N, pulses are separated by exactly N+1 source ticks.
- R5: At each output boundary, sum = remainder + `frac_num` is formed. If sum >= D (the effective denominator), the next period lasts N+2 ticks and the new remainder is sum − D. Otherwise the next period lasts N+1 ticks and the remainder becomes sum. The average period is therefore N+1+num/den when num < den.
- R6: A `frac_den` of 0 acts as 1. A remainder that would still be >= D after subtraction is clamped to D−1.
- R7: `int_div`, `frac_num` and `frac_den` are sampled only on the source tick that ends a period, or while the divider is off. Changes made at any other time have no effect on the period in progress.
- R8: Each pulse lasts one clock cycle. It is asserted in the cycle after the source tick that completes a period.
- R9: After the divider is switched on (gate high with a valid select), the first period is N+1 ticks with no stretch. N is the value of `int_div` in the last cycle the divider was off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock that carries both source strobes |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_alt_stb | input | 1 | Tick strobe of the alternate (PLL-derived) source |
| src_bus_stb | input | 1 | Tick strobe of the bus clock source |
| sel_code | input | 2 | Source select: 0 off, 1 alternate, 2 bus, 3 off |
| gate_en | input | 1 | Controller clock gate, 1 to run |
| int_div | input | 8 | Integer part N of the ratio (0..255) |
| frac_den | input | 6 | Fraction denominator (1..63, 0 acts as 1) |
| frac_num | input | 6 | Fraction numerator (0..63) |
| ctl_clk_en | output | 1 | Divided controller clock-enable pulse |

## Verification
A purely integer ratio with dense strobes separates the N+1 spacing from any accumulator effect. A small fraction such as 1/3 then shows whether the stretch lands on exactly the right period. Sparse random strobes on the selected source, with busy strobes on the other source, show that only the chosen source is counted. The divider is also held off with the gate and with the reserved select codes, which checks both that no pulse leaks out and that the restart begins with an unstretched period. Directed cases cover a zero denominator, a numerator above the denominator, a divisor change in mid-period and release from reset while already running. A long random run then compares every cycle against a tick-countdown model held in the bench.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;
  // Source select encoding; codes other than ALT and BUS stop the divider.
  typedef enum logic [1:0] {
    SRC_OFF = 2'd0,
    SRC_ALT = 2'd1,
    SRC_BUS = 2'd2,
    SRC_RSV = 2'd3
  } src_sel_e;
endpackage

// File: rtl/fdiv_src_gate.sv
module fdiv_src_gate
  import fdiv_pkg::*;
(
  input  logic       gate_en,
  input  logic [1:0] sel_code,
  input  logic       src_alt_stb,
  input  logic       src_bus_stb,
  output logic       src_on,
  output logic       src_tick
);
  src_sel_e sel;

  assign sel = src_sel_e'(sel_code);

  always_comb begin
    src_on   = 1'b0;
    src_tick = 1'b0;
    if (gate_en) begin
      unique case (sel)
        SRC_ALT: begin src_on = 1'b1; src_tick = src_alt_stb; end
        SRC_BUS: begin src_on = 1'b1; src_tick = src_bus_stb; end
        default: begin src_on = 1'b0; src_tick = 1'b0; end
      endcase
    end
  end
endmodule

// File: rtl/fdiv_frac_accum.sv
module fdiv_frac_accum #(
  parameter int FW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          src_on,
  input  logic          boundary,
  input  logic [FW-1:0] frac_num,
  input  logic [FW-1:0] frac_den,
  output logic          stretch_q
);
  localparam int SW = FW + 1;

  logic [FW-1:0] rem_q;
  logic [SW-1:0] step_res;

  // Returns {stretch, new remainder} for one output boundary.
  function automatic logic [SW-1:0] frac_step(input logic [FW-1:0] rem,
                                              input logic [FW-1:0] num,
                                              input logic [FW-1:0] den);
    logic [FW-1:0] eff_den;
    logic [SW-1:0] sum;
    logic [SW-1:0] left;
    eff_den = (den == '0) ? FW'(1) : den;
    sum     = {1'b0, rem} + {1'b0, num};
    if (sum >= {1'b0, eff_den}) begin
      left = sum - {1'b0, eff_den};
      if (left >= {1'b0, eff_den}) left = {1'b0, eff_den} - SW'(1);
      return {1'b1, left[FW-1:0]};
    end
    return {1'b0, sum[FW-1:0]};
  endfunction

  assign step_res = frac_step(rem_q, frac_num, frac_den);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q     <= '0;
      stretch_q <= 1'b0;
    end else if (!src_on) begin
      rem_q     <= '0;
      stretch_q <= 1'b0;
    end else if (boundary) begin
      rem_q     <= step_res[FW-1:0];
      stretch_q <= step_res[FW];
    end
  end

  // R5
  stretch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_on && !boundary) |=> $stable(stretch_q));

  // R3
  off_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !src_on |=> (rem_q == '0 && !stretch_q));
endmodule

// File: rtl/fdiv_period_ctr.sv
module fdiv_period_ctr #(
  parameter int NW    = 8,
  parameter int DEF_N = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          src_on,
  input  logic          src_tick,
  input  logic          stretch,
  input  logic [NW-1:0] int_div,
  output logic          boundary
);
  localparam int            CW    = NW + 1;
  localparam logic [NW-1:0] DEF_V = NW'(DEF_N);

  logic [CW-1:0] cnt_q;
  logic [NW-1:0] shadow_q;

  // Index of the last tick of a period of N+1+stretch ticks.
  function automatic logic [CW-1:0] last_idx(input logic [NW-1:0] n,
                                             input logic s);
    return {1'b0, n} + CW'(s);
  endfunction

  assign boundary = src_tick && (cnt_q == last_idx(shadow_q, stretch));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      shadow_q <= DEF_V;
    end else if (!src_on || boundary) begin
      cnt_q    <= '0;
      shadow_q <= int_div;
    end else if (src_tick) begin
      cnt_q    <= cnt_q + CW'(1);
    end
  end

  // R7
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= last_idx(shadow_q, stretch));

  // R7
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_on && !src_tick) |=> $stable(shadow_q));
endmodule

// File: rtl/fracdiv_clkgen.sv
module fracdiv_clkgen #(
  parameter int NW    = 8,
  parameter int FW    = 6,
  parameter int DEF_N = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          src_alt_stb,
  input  logic          src_bus_stb,
  input  logic [1:0]    sel_code,
  input  logic          gate_en,
  input  logic [NW-1:0] int_div,
  input  logic [FW-1:0] frac_den,
  input  logic [FW-1:0] frac_num,
  output logic          ctl_clk_en
);
  logic src_on;
  logic src_tick;
  logic boundary;
  logic stretch_q;

  fdiv_src_gate u_src (
    .gate_en     (gate_en),
    .sel_code    (sel_code),
    .src_alt_stb (src_alt_stb),
    .src_bus_stb (src_bus_stb),
    .src_on      (src_on),
    .src_tick    (src_tick)
  );

  fdiv_period_ctr #(.NW(NW), .DEF_N(DEF_N)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_on   (src_on),
    .src_tick (src_tick),
    .stretch  (stretch_q),
    .int_div  (int_div),
    .boundary (boundary)
  );

  fdiv_frac_accum #(.FW(FW)) u_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_on    (src_on),
    .boundary  (boundary),
    .frac_num  (frac_num),
    .frac_den  (frac_den),
    .stretch_q (stretch_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_clk_en <= 1'b0;
    else        ctl_clk_en <= boundary;
  end

  // R8
  pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_clk_en |-> $past(src_tick));

  // R3
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_en |=> !ctl_clk_en);

  // R2
  sel_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_code == 2'd0 || sel_code == 2'd3) |=> !ctl_clk_en);
endmodule

// File: tb/fracdiv_clkgen_tb.sv
`timescale 1ns/1ps
module fracdiv_clkgen_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       src_alt_stb, src_bus_stb, gate_en;
  logic [1:0] sel_code;
  logic [7:0] int_div;
  logic [5:0] frac_den, frac_num;
  logic       ctl_clk_en;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // bench model state: ticks left in the current period, fraction remainder
  int m_left = 16;
  int m_rem  = 0;

  always #5 clk = ~clk;

  fracdiv_clkgen u_dut (
    .clk(clk), .rst_n(rst_n), .src_alt_stb(src_alt_stb), .src_bus_stb(src_bus_stb),
    .sel_code(sel_code), .gate_en(gate_en), .int_div(int_div),
    .frac_den(frac_den), .frac_num(frac_num), .ctl_clk_en(ctl_clk_en)
  );

  // Extra tick owed to the next period, restated from the rule in R5/R6.
  function automatic int owed_tick(inout int rem, input int num, input int den);
    int d, t;
    d = (den == 0) ? 1 : den;
    t = rem + num;
    if (t < d) begin
      rem = t;
      return 0;
    end
    rem = (t - d < d) ? (t - d) : (d - 1);
    return 1;
  endfunction

  task automatic check(input bit got, input bit want, input string tag);
    total++;
    if (got !== want) begin
      bad++;
      $display("FAIL %s: ctl_clk_en=%0b expected=%0b at %0t", tag, got, want, $time);
    end
  endtask

  // One clock cycle with the inputs already applied; compare after the edge.
  task automatic step(input string tag);
    bit run, tick, want;
    run  = gate_en && (sel_code == 2'd1 || sel_code == 2'd2);
    tick = run && ((sel_code == 2'd1) ? src_alt_stb : src_bus_stb);
    want = 1'b0;
    if (!rst_n) begin
      m_left = 16;
      m_rem  = 0;
    end else if (!run) begin
      m_left = int_div + 1;
      m_rem  = 0;
    end else if (tick) begin
      if (m_left == 1) begin
        want   = 1'b1;
        m_left = int_div + 1 + owed_tick(m_rem, frac_num, frac_den);
      end else begin
        m_left--;
      end
    end
    @(posedge clk);
    #1;
    check(ctl_clk_en, want, tag);
    @(negedge clk);
  endtask

  task automatic run_cycles(input int n, input string tag);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  // Count cycles between two successive pulses (directed spacing check).
  task automatic gap_check(input int want, input string tag);
    int n;
    n = 0;
    while (ctl_clk_en !== 1'b1 && n < 600) begin step(tag); n++; end
    n = 0;
    step(tag);
    n = 1;
    while (ctl_clk_en !== 1'b1 && n < 600) begin step(tag); n++; end
    total++;
    if (n != want) begin
      bad++;
      $display("FAIL %s: pulse gap=%0d expected=%0d", tag, n, want);
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0c1c));
    rst_n = 1'b0; gate_en = 1'b1; sel_code = 2'd2;
    src_alt_stb = 1'b0; src_bus_stb = 1'b1;
    int_div = 8'd3; frac_den = 6'd1; frac_num = 6'd0;
    @(negedge clk);
    // R1: held in reset, then released while running with default divisor 15
    run_cycles(4, "R1");
    rst_n = 1'b1;
    run_cycles(40, "R1");

    // R2: alternate source counted, bus strobes busy but ignored
    sel_code = 2'd1; int_div = 8'd2;
    for (int i = 0; i < 80; i++) begin
      src_alt_stb = ($urandom % 3) == 0;
      src_bus_stb = 1'b1;
      step("R2");
    end
    // R2: reserved and off codes give nothing
    sel_code = 2'd3; src_alt_stb = 1'b1; run_cycles(12, "R2");
    sel_code = 2'd0; run_cycles(12, "R2");
    sel_code = 2'd2; src_alt_stb = 1'b1;
    for (int i = 0; i < 60; i++) begin
      src_bus_stb = ($urandom % 2) == 0;
      step("R2");
    end

    // R4: integer ratio, dense strobes
    src_bus_stb = 1'b1; int_div = 8'd4; frac_num = 6'd0; frac_den = 6'd7;
    run_cycles(30, "R4");
    gap_check(5, "R4");
    int_div = 8'd0;
    run_cycles(10, "R4");

    // R5: fraction 1/3 on N=2, mean period 3.33 ticks
    int_div = 8'd2; frac_num = 6'd1; frac_den = 6'd3;
    run_cycles(80, "R5");

    // R3 then R9: gate off clears state, restart unstretched
    gate_en = 1'b0; run_cycles(10, "R3");
    int_div = 8'd5; frac_num = 6'd5; frac_den = 6'd6;
    gate_en = 1'b1;
    run_cycles(4, "R9");
    gap_check(7, "R9");
    run_cycles(30, "R9");

    // R6: zero denominator and numerator above denominator
    int_div = 8'd1; frac_den = 6'd0; frac_num = 6'd5;
    run_cycles(40, "R6");
    frac_den = 6'd7; frac_num = 6'd60;
    run_cycles(40, "R6");

    // R7: divisor change in mid-period takes effect only at the next boundary
    frac_num = 6'd0; frac_den = 6'd1; int_div = 8'd9;
    run_cycles(25, "R7");
    while (ctl_clk_en !== 1'b1) step("R7");
    run_cycles(3, "R7");
    int_div = 8'd2;
    run_cycles(20, "R7");

    // R8: random configurations and strobes, cycle-by-cycle
    for (int i = 0; i < 3000; i++) begin
      if (($urandom % 40) == 0) begin
        int_div  = 8'($urandom % 9);
        frac_num = 6'($urandom % 64);
        frac_den = 6'($urandom % 64);
        sel_code = (($urandom % 6) == 0) ? 2'($urandom % 4) : 2'(1 + $urandom % 2);
        gate_en  = ($urandom % 10) != 0;
      end
      src_alt_stb = ($urandom % 4) != 0;
      src_bus_stb = ($urandom % 4) != 0;
      step("R8");
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule